// File: doc/BRIEF.md
# Wave-Ordered Atomic Append Counter

This block makes counter updates from shader waves take effect in the order the waves were launched, whatever order their requests arrive in. It holds four independent 32-bit counters. When a wave launches, a dispatch strobe names the wave and the counter it will use. The block stamps the wave with that counter's next launch number.

A wave later sends an update request that carries its execution mask. The request waits in a per-counter pending table until the counter's expected launch number equals the wave's stamp. The block then adds the number of active lanes to the counter. It returns the value from before the add, marked for delivery to every lane of the wave.

A request without the release flag lets the wave keep the counter: the expected number does not move, so only that wave's next request can match. A release request moves the counter on to the next wave. A request with no active lanes adds nothing, but it still takes part in the ordering. Each wave is expected to have at most one request outstanding at a time.

Top module: `ordered_append`

## Requirements
- R1: There are four counters. `req_ctr` (2 bits) selects one, and an update to one counter never changes another.
- R2: The increment is the number of set bits in the 32-bit `req_mask`. `resp_count` reports the increment that was applied.
- R3: A pending request is granted only when its wave's launch number equals the counter's expected number. A request that arrives early waits while older waves are served.
- R4: `resp_lanes` is all ones on every response, whatever the request mask was.
- R5: A granted request without release (`req_release`=0) leaves the expected number unchanged. No other wave's request on that counter is granted until the owning wave sends a release request.
- R6: A granted release request advances that counter's expected number by exactly one.
- R7: A request with an all-zero mask is accepted and granted in order. It adds zero, and if it carries release it lets the next wave proceed.
- R8: `resp_value` is the counter value before the add. Counters wrap modulo 2^32.
- R9: Each dispatch of a wave on a counter stamps it with that counter's dispatch count since reset, starting at zero.
- R10: Each counter has a pending table of 16 entries. `req_ready` is low while the table of the counter named by `req_ctr` is full.
- R11: Reset clears every counter value, every expected number, every dispatch count and every pending table. While reset is held, `resp_valid` is low and `req_ready` is high.
- R12: At most one response is produced per cycle. When several counters have a matching request in the same cycle, the lowest counter index goes first.
- R13: `resp_wave`, `resp_ctr` and `resp_last` echo the granted request's wave id, counter id and last flag. The response appears one clock after the cycle in which the request becomes grantable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A wave launches this cycle |
| disp_wave | input | 5 | Id of the launching wave |
| disp_ctr | input | 2 | Counter whose launch order the wave joins |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Pending table of `req_ctr` has room |
| req_wave | input | 5 | Requesting wave id |
| req_ctr | input | 2 | Target counter |
| req_mask | input | 32 | Execution mask of the wave |
| req_release | input | 1 | Hand the counter to the next wave after this add |
| req_last | input | 1 | Last-request flag, echoed on the response |
| resp_valid | output | 1 | Response present this cycle |
| resp_wave | output | 5 | Wave receiving the response |
| resp_ctr | output | 2 | Counter that was updated |
| resp_value | output | 32 | Counter value before the add |
| resp_count | output | 6 | Lanes added |
| resp_lanes | output | 32 | Lanes that receive `resp_value` |
| resp_last | output | 1 | Echo of the last flag |

## Verification
Requests are sent in reverse and interleaved order against launch order. A design that served arrival order would hand out values in the wrong sequence. An owned counter is held while a younger wave waits in the table. A design that advanced on every grant would let the younger wave in between the owner's two adds. Zero-lane requests sit at the head of each batch, so a design that dropped them or skipped their release would stall the whole batch. The bench fills a table to exactly sixteen entries and lines up matches on two counters in the same cycle, which exposes an off-by-one full flag and a wrong arbitration priority.

// File: rtl/ordered_append_pkg.sv
package ordered_append_pkg;
  localparam int NCTR   = 4;
  localparam int CTR_W  = $clog2(NCTR);
  localparam int DATA_W = 32;
  localparam int LANES  = 32;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int NWAVE  = 32;
  localparam int WAVE_W = $clog2(NWAVE);
  localparam int SEQ_W  = 8;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [WAVE_W-1:0] wave;
    logic [CNT_W-1:0]  cnt;
    logic              rel;
    logic              last;
  } pend_t;

  function automatic logic [CNT_W-1:0] lane_count(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + CNT_W'(m[i]);
    return s;
  endfunction
endpackage

// File: rtl/oa_tagger.sv
module oa_tagger
  import ordered_append_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [WAVE_W-1:0] disp_wave,
  input  logic [CTR_W-1:0]  disp_ctr,
  input  logic [WAVE_W-1:0] rd_wave,
  output logic [SEQ_W-1:0]  rd_seq
);
  logic [SEQ_W-1:0] cnt_q [NCTR];
  logic [SEQ_W-1:0] cnt_n [NCTR];
  logic [SEQ_W-1:0] tag_q [NWAVE];
  logic [SEQ_W-1:0] tag_n [NWAVE];

  always_comb begin
    cnt_n = cnt_q;
    tag_n = tag_q;
    if (disp_valid) begin
      tag_n[disp_wave] = cnt_q[disp_ctr];
      cnt_n[disp_ctr]  = cnt_q[disp_ctr] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTR; c++) cnt_q[c] <= '0;
      for (int w = 0; w < NWAVE; w++) tag_q[w] <= '0;
    end else if (disp_valid) begin
      cnt_q <= cnt_n;
      tag_q <= tag_n;
    end
  end

  assign rd_seq = tag_q[rd_wave];
endmodule

// File: rtl/oa_pend.sv
module oa_pend
  import ordered_append_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  pend_t            wr_data,
  input  logic [SEQ_W-1:0] exp_seq,
  input  logic             pop,
  output logic             full,
  output logic             hit,
  output pend_t            hit_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_n;
  pend_t            ent_q [DEPTH];
  pend_t            ent_n [DEPTH];
  logic [IDX_W-1:0] free_idx, hit_idx;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IDX_W'(i);
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (vld_q[i] && ent_q[i].seq == exp_seq) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    hit_data = ent_q[hit_idx];
    full     = &vld_q;
  end

  always_comb begin
    vld_n = vld_q;
    ent_n = ent_q;
    if (pop) vld_n[hit_idx] = 1'b0;
    if (wr_en) begin
      vld_n[free_idx] = 1'b1;
      ent_n[free_idx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (wr_en || pop) begin
      vld_q <= vld_n;
      ent_q <= ent_n;
    end
  end
endmodule

// File: rtl/oa_core.sv
module oa_core
  import ordered_append_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCTR-1:0]         hit,
  input  pend_t [NCTR-1:0]        hit_data,
  output logic [NCTR-1:0]         pop,
  output logic [NCTR*SEQ_W-1:0]   exp_flat,
  output logic                    gnt_valid,
  output logic [CTR_W-1:0]        gnt_ctr,
  output logic                    gnt_rel,
  output logic                    resp_valid,
  output logic [WAVE_W-1:0]       resp_wave,
  output logic [CTR_W-1:0]        resp_ctr,
  output logic [DATA_W-1:0]       resp_value,
  output logic [CNT_W-1:0]        resp_count,
  output logic                    resp_last
);
  logic [DATA_W-1:0] val_q [NCTR];
  logic [DATA_W-1:0] val_n [NCTR];
  logic [SEQ_W-1:0]  exp_q [NCTR];
  logic [SEQ_W-1:0]  exp_n [NCTR];
  pend_t             gnt;

  logic              rv_q, rv_n;
  logic [WAVE_W-1:0] rw_q, rw_n;
  logic [CTR_W-1:0]  rc_q, rc_n;
  logic [DATA_W-1:0] rval_q, rval_n;
  logic [CNT_W-1:0]  rcnt_q, rcnt_n;
  logic              rl_q, rl_n;

  // fixed priority: lowest counter index wins
  always_comb begin
    gnt_valid = 1'b0;
    gnt_ctr   = '0;
    for (int c = NCTR - 1; c >= 0; c--)
      if (hit[c]) begin
        gnt_valid = 1'b1;
        gnt_ctr   = CTR_W'(c);
      end
    gnt     = hit_data[gnt_ctr];
    gnt_rel = gnt.rel;
    pop     = '0;
    if (gnt_valid) pop[gnt_ctr] = 1'b1;
  end

  always_comb begin
    val_n  = val_q;
    exp_n  = exp_q;
    rv_n   = gnt_valid;
    rw_n   = rw_q;
    rc_n   = rc_q;
    rval_n = rval_q;
    rcnt_n = rcnt_q;
    rl_n   = rl_q;
    if (gnt_valid) begin
      val_n[gnt_ctr] = val_q[gnt_ctr] + DATA_W'(gnt.cnt);
      if (gnt.rel) exp_n[gnt_ctr] = exp_q[gnt_ctr] + 1'b1;
      rw_n   = gnt.wave;
      rc_n   = gnt_ctr;
      rval_n = val_q[gnt_ctr];
      rcnt_n = gnt.cnt;
      rl_n   = gnt.last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTR; c++) begin
        val_q[c] <= '0;
        exp_q[c] <= '0;
      end
      rv_q   <= 1'b0;
      rw_q   <= '0;
      rc_q   <= '0;
      rval_q <= '0;
      rcnt_q <= '0;
      rl_q   <= 1'b0;
    end else begin
      rv_q <= rv_n;
      if (gnt_valid) begin
        val_q  <= val_n;
        exp_q  <= exp_n;
        rw_q   <= rw_n;
        rc_q   <= rc_n;
        rval_q <= rval_n;
        rcnt_q <= rcnt_n;
        rl_q   <= rl_n;
      end
    end
  end

  for (genvar c = 0; c < NCTR; c++) begin : g_exp
    assign exp_flat[c*SEQ_W +: SEQ_W] = exp_q[c];
  end

  assign resp_valid = rv_q;
  assign resp_wave  = rw_q;
  assign resp_ctr   = rc_q;
  assign resp_value = rval_q;
  assign resp_count = rcnt_q;
  assign resp_last  = rl_q;
endmodule

// File: rtl/ordered_append.sv
module ordered_append
  import ordered_append_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [WAVE_W-1:0] disp_wave,
  input  logic [CTR_W-1:0]  disp_ctr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WAVE_W-1:0] req_wave,
  input  logic [CTR_W-1:0]  req_ctr,
  input  logic [LANES-1:0]  req_mask,
  input  logic              req_release,
  input  logic              req_last,
  output logic              resp_valid,
  output logic [WAVE_W-1:0] resp_wave,
  output logic [CTR_W-1:0]  resp_ctr,
  output logic [DATA_W-1:0] resp_value,
  output logic [CNT_W-1:0]  resp_count,
  output logic [LANES-1:0]  resp_lanes,
  output logic              resp_last
);
  logic [SEQ_W-1:0]       req_seq;
  logic [NCTR-1:0]        full, hit, pop;
  pend_t [NCTR-1:0]       hit_data;
  logic [NCTR*SEQ_W-1:0]  exp_flat;
  logic                   gnt_valid, gnt_rel;
  logic [CTR_W-1:0]       gnt_ctr;
  logic                   accept;
  pend_t                  new_ent;

  oa_tagger u_tag (
    .clk, .rst_n, .disp_valid, .disp_wave, .disp_ctr,
    .rd_wave(req_wave), .rd_seq(req_seq)
  );

  assign req_ready = !full[req_ctr];
  assign accept    = req_valid && req_ready;

  always_comb begin
    new_ent.seq  = req_seq;
    new_ent.wave = req_wave;
    new_ent.cnt  = lane_count(req_mask);
    new_ent.rel  = req_release;
    new_ent.last = req_last;
  end

  for (genvar c = 0; c < NCTR; c++) begin : g_pend
    oa_pend #(.DEPTH(DEPTH)) u_pend (
      .clk, .rst_n,
      .wr_en   (accept && (req_ctr == CTR_W'(c))),
      .wr_data (new_ent),
      .exp_seq (exp_flat[c*SEQ_W +: SEQ_W]),
      .pop     (pop[c]),
      .full    (full[c]),
      .hit     (hit[c]),
      .hit_data(hit_data[c])
    );
  end

  oa_core u_core (
    .clk, .rst_n, .hit, .hit_data, .pop, .exp_flat,
    .gnt_valid, .gnt_ctr, .gnt_rel,
    .resp_valid, .resp_wave, .resp_ctr, .resp_value, .resp_count, .resp_last
  );

  // every lane of the wave receives the pre-add value
  assign resp_lanes = {LANES{resp_valid}};
endmodule

// File: rtl/ordered_append_chk.sv
module ordered_append_chk
  import ordered_append_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   resp_valid,
  input logic [LANES-1:0]       resp_lanes,
  input logic [CTR_W-1:0]       resp_ctr,
  input logic [DATA_W-1:0]      resp_value,
  input logic [CNT_W-1:0]       resp_count,
  input logic [NCTR-1:0]        pop,
  input logic                   gnt_valid,
  input logic                   gnt_rel,
  input logic [CTR_W-1:0]       gnt_ctr,
  input logic [NCTR*SEQ_W-1:0]  exp_flat
);
  a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

  a_r4_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (&resp_lanes));

  a_r5_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_rel) |=> $stable(exp_flat));

  a_r6_release_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_rel) |=>
      exp_flat[$past(gnt_ctr)*SEQ_W +: SEQ_W] ==
      SEQ_W'($past(exp_flat[gnt_ctr*SEQ_W +: SEQ_W]) + 1'b1));

  a_r8_value_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(resp_valid) && resp_ctr == $past(resp_ctr)) |->
      resp_value == $past(resp_value) + DATA_W'($past(resp_count)));
endmodule

bind ordered_append ordered_append_chk u_chk (
  .clk, .rst_n, .resp_valid, .resp_lanes, .resp_ctr, .resp_value, .resp_count,
  .pop, .gnt_valid, .gnt_rel, .gnt_ctr, .exp_flat
);

// File: tb/ordered_append_tb.sv
module ordered_append_tb;
  import ordered_append_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [WAVE_W-1:0] disp_wave = '0;
  logic [CTR_W-1:0] disp_ctr = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [WAVE_W-1:0] req_wave = '0;
  logic [CTR_W-1:0] req_ctr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic req_release = 1'b0;
  logic req_last = 1'b0;
  logic resp_valid;
  logic [WAVE_W-1:0] resp_wave;
  logic [CTR_W-1:0] resp_ctr;
  logic [DATA_W-1:0] resp_value;
  logic [CNT_W-1:0] resp_count;
  logic [LANES-1:0] resp_lanes;
  logic resp_last;

  always #2 clk = ~clk;

  ordered_append u_dut (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] model [4];

  int log_n = 0;
  int log_wave [512];
  int log_ctr [512];
  logic [31:0] log_val [512];
  int log_cnt [512];
  logic [31:0] log_lanes [512];
  logic log_last [512];

  always @(negedge clk)
    if (rst_n && resp_valid && log_n < 512) begin
      log_wave[log_n]  = resp_wave;
      log_ctr[log_n]   = resp_ctr;
      log_val[log_n]   = resp_value;
      log_cnt[log_n]   = resp_count;
      log_lanes[log_n] = resp_lanes;
      log_last[log_n]  = resp_last;
      log_n++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pc(input logic [31:0] m);
    int s = 0;
    for (int i = 0; i < 32; i++) s += m[i];
    return s;
  endfunction

  function automatic logic [31:0] mask_of(input int c, input int i, input int n);
    if (i == 0) return 32'h0;
    if (i == n - 1) return 32'hFFFF_FFFF;
    return (32'h9E37_79B1 * (i + 1 + 8 * c)) ^ (32'h1 << i);
  endfunction

  task automatic dispatch(input int w, input int c);
    @(negedge clk);
    disp_valid = 1'b1; disp_wave = WAVE_W'(w); disp_ctr = CTR_W'(c);
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic request(input int w, input int c, input logic [31:0] m,
                         input bit rel, input bit last);
    @(negedge clk);
    req_valid = 1'b1; req_wave = WAVE_W'(w); req_ctr = CTR_W'(c);
    req_mask = m; req_release = rel; req_last = last;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_log(input int target);
    for (int k = 0; k < 300 && log_n < target; k++) @(negedge clk);
  endtask

  task automatic check_entry(input int j, input int w, input int c,
                             input logic [31:0] m, input bit last);
    chk(log_wave[j] == w, "R3 R9 wave order", log_wave[j], w);
    chk(log_ctr[j] == c, "R1 R13 counter echo", log_ctr[j], c);
    chk(log_val[j] == model[c], "R8 pre-add value", log_val[j], model[c]);
    chk(log_cnt[j] == pc(m), (m == 0) ? "R7 zero lanes" : "R2 lane count",
        log_cnt[j], pc(m));
    chk(log_lanes[j] == 32'hFFFF_FFFF, "R4 all lanes", log_lanes[j], 32'hFFFF_FFFF);
    chk(log_last[j] == last, "R13 last echo", log_last[j], last);
    model[c] = model[c] + pc(m);
  endtask

  // order 0: launch order, 1: reverse, 2: odd positions first
  task automatic run_batch(input int c, input int n, input int order);
    int l0 = log_n;
    int i;
    for (int k = 0; k < n; k++) dispatch(k, c);
    for (int k = 0; k < n; k++) begin
      if (order == 0) i = k;
      else if (order == 1) i = n - 1 - k;
      else i = (k < n / 2) ? (2 * k + 1) : (2 * (k - n / 2));
      request(i, c, mask_of(c, i, n), 1'b1, i[0]);
    end
    wait_log(l0 + n);
    chk(log_n == l0 + n, "R3 batch complete", log_n - l0, n);
    for (int j = 0; j < n; j++)
      if (j + l0 < log_n) check_entry(l0 + j, j, c, mask_of(c, j, n), j[0]);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int l0;
    for (int c = 0; c < 4; c++) model[c] = 0;
    repeat (3) @(negedge clk);
    chk(resp_valid == 1'b0, "R11 reset resp_valid", resp_valid, 0);
    chk(req_ready == 1'b1, "R11 reset req_ready", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // sweep: every counter, three arrival orders
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 3; o++) run_batch(c, 8, o);

    // R5 ownership on counter 0: wave 10 holds, wave 11 waits
    dispatch(10, 0);
    dispatch(11, 0);
    l0 = log_n;
    request(11, 0, 32'h0000_00F0, 1'b1, 1'b0);
    request(10, 0, 32'h0000_0007, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk(log_n == l0 + 1, "R5 younger wave held", log_n - l0, 1);
    if (log_n > l0) check_entry(l0, 10, 0, 32'h0000_0007, 1'b0);
    request(10, 0, 32'h0000_0003, 1'b1, 1'b1);
    wait_log(l0 + 3);
    chk(log_n == l0 + 3, "R6 release lets next wave in", log_n - l0, 3);
    if (log_n >= l0 + 3) begin
      check_entry(l0 + 1, 10, 0, 32'h0000_0003, 1'b1);
      check_entry(l0 + 2, 11, 0, 32'h0000_00F0, 1'b0);
    end

    // R12 priority: counter 1 and 2 both become grantable together
    dispatch(20, 1); dispatch(21, 1);
    dispatch(22, 2); dispatch(23, 2);
    l0 = log_n;
    request(23, 2, 32'h0000_0011, 1'b1, 1'b0);
    request(21, 1, 32'h0000_0101, 1'b1, 1'b0);
    request(22, 2, 32'h0000_0001, 1'b1, 1'b0);
    request(20, 1, 32'h0000_000F, 1'b1, 1'b0);
    wait_log(l0 + 4);
    chk(log_n == l0 + 4, "R12 all granted", log_n - l0, 4);
    if (log_n >= l0 + 4) begin
      check_entry(l0,     22, 2, 32'h0000_0001, 1'b0);
      check_entry(l0 + 1, 20, 1, 32'h0000_000F, 1'b0);
      check_entry(l0 + 2, 21, 1, 32'h0000_0101, 1'b0);
      check_entry(l0 + 3, 23, 2, 32'h0000_0011, 1'b0);
      chk(log_ctr[l0 + 1] == 1, "R12 lower index first", log_ctr[l0 + 1], 1);
    end

    // R10 full table on counter 3
    for (int w = 0; w < 16; w++) dispatch(w, 3);
    l0 = log_n;
    for (int w = 15; w >= 1; w--) request(w, 3, 32'h1 << w, 1'b1, 1'b0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready with 15 pending", req_ready, 1);
    request(0, 3, 32'h3, 1'b1, 1'b0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 not ready when full", req_ready, 0);
    chk(log_n == l0, "R3 nothing granted before head", log_n - l0, 0);
    wait_log(l0 + 16);
    chk(log_n == l0 + 16, "R10 table drains", log_n - l0, 16);
    for (int j = 0; j < 16; j++)
      if (l0 + j < log_n) check_entry(l0 + j, j, 3, (j == 0) ? 32'h3 : (32'h1 << j), 1'b0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after drain", req_ready, 1);

    // R11 reset mid-run clears values and ordering
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(resp_valid == 1'b0, "R11 resp_valid in reset", resp_valid, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) model[c] = 0;
    run_batch(0, 4, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule